// File: doc/BRIEF.md
# Serial Wake-Up Sequence Detector

This block watches a slow serial clock, a serial command wire and a single-bit side line while the rest of the device sleeps. It decides whether a valid wake request has arrived. A request starts on a falling edge of the serial clock where the command wire reads 0. The following rising edge must then read the command wire as 1. The side line sampled at that falling edge selects which sleep state is left: a light nap or a deep power-down.

Address checking is set by configuration. With address checking on, the detector reads a six-bit device address from six data pins and compares it with the device's own ID. It samples either at the first rising edge after the qualifying falling edge, which is half a serial cycle later, or at the second rising edge, one and a half cycles later. With address checking off, the pins are ignored and the command pattern alone wakes the device.

The row and column buses must stay idle in a window around the qualifying edge. A clock-stable input must also be asserted at that edge. The serial inputs and the idle state of the buses pass through the same synchronizer depth, so the quiet window stays aligned with the sampled edges. The result is a one-cycle exit strobe in the system clock domain, with the exit type held beside it.

Top module: `wake_seq_detect`

## Requirements
- R1: After reset, `exit_pulse` is 0 and no wake is pending.
- R2: A wake attempt needs `cmd`=0 at a falling edge of `sck` and `cmd`=1 at the next rising edge. On the accepted strobe, `exit_is_pdn` equals the `sio0` value seen at that falling edge: 0 means nap, 1 means power-down.
- R3: With `addr_ignore`=0, the exit happens only if the sampled `dev_addr` equals `dev_id`. Otherwise the attempt ends with no strobe.
- R4: With `addr_late`=0, the address is taken at the first rising edge after the qualifying falling edge. With `addr_late`=1, it is taken at the second rising edge. The value on the pins at the other rising edge has no effect.
- R5: With `addr_ignore`=1, `dev_addr` has no effect, and a valid command pattern always leads to an exit.
- R6: Both `row_bus` and `col_bus` must be all-zero in three spans: the QUIET_PRE system cycles before the cycle in which the falling edge arrives, that cycle itself, and the QUIET_POST cycles after it. A non-zero value anywhere in these spans cancels the exit.
- R7: If `clk_stable` is 0 when the qualifying falling edge is seen, no exit occurs.
- R8: The attempt fails if `cmd` is 1 at the falling edge or 0 at the following rising edge. A failed attempt, for any reason, returns the detector to idle without a strobe, and a later valid attempt is still recognized.
- R9: Each accepted wake gives `exit_pulse` high for exactly one `clk` cycle, a few cycles after the deciding serial edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Slow serial clock, asynchronous to `clk` |
| cmd | input | 1 | Serial command wire |
| sio0 | input | 1 | Side line selecting exit type |
| dev_addr | input | ADDR_W | Device address pins |
| row_bus | input | ROW_W | Row request inputs, must be idle (zero) near the wake edge |
| col_bus | input | COL_W | Column request inputs, must be idle (zero) near the wake edge |
| clk_stable | input | 1 | High-speed clock has been stable long enough |
| addr_ignore | input | 1 | 1: skip address compare |
| addr_late | input | 1 | 1: take address at second rising edge |
| dev_id | input | ADDR_W | This device's ID |
| exit_pulse | output | 1 | One-cycle wake strobe |
| exit_is_pdn | output | 1 | Exit type with the strobe: 0 nap, 1 power-down |

## Verification
The bench uses the default parameters: two synchronizer stages, a six-bit address, QUIET_PRE of 4 and QUIET_POST of 3. It drives the serial clock with a half period of 8 system cycles. This short quiet window lets single-cycle bus bursts be placed inside either side of the window, and also just outside it, so both rejection and tolerance can be seen. The wide half period keeps the address change between the two rising edges well clear of the synchronizer, so the half-cycle and one-and-a-half-cycle sampling points can be told apart.

// File: rtl/wake_pkg.sv
// Package: shared types for the serial wake-up detector.
// Assumes: nothing beyond standard SystemVerilog.
package wake_pkg;

    // Sequence progress of one wake attempt
    typedef enum logic [2:0] {
        WS_IDLE    = 3'd0,
        WS_WAIT_R1 = 3'd1,
        WS_WAIT_F2 = 3'd2,
        WS_WAIT_R2 = 3'd3,
        WS_SETTLE  = 3'd4
    } wake_state_t;

endpackage

// File: rtl/wake_in_sync.sv
// Module: wake_in_sync
// Multi-stage flop chain. Used both to bring the asynchronous serial inputs
// into the clk domain and to delay clk-domain signals by the same depth, so
// that both arrive aligned.
// Assumes: each bit of d is individually safe to synchronize (quasi-static
// around the serial edges).
module wake_in_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage: capture raw input
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= '0;
                else        pipe[i] <= d;
            end
        end else begin : g_next
            // Later stages: shift along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= '0;
                else        pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/wake_quiet_mon.sv
// Module: wake_quiet_mon
// Tracks whether the row/column buses stayed idle around a wake edge.
// pre_ok: at least QUIET_PRE consecutive idle cycles precede the current one.
// On start, a window covering the current cycle plus QUIET_POST following
// cycles is watched; any busy cycle sets post_bad until the next start.
// Assumes: idle is already aligned with the synchronized serial edges.
module wake_quiet_mon #(
    parameter int QUIET_PRE  = 4,
    parameter int QUIET_POST = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic start,
    output logic pre_ok,
    output logic hold_busy,
    output logic post_bad
);

    localparam int PRE_W  = $clog2(QUIET_PRE + 2);
    localparam int POST_W = $clog2(QUIET_POST + 2);
    localparam logic [PRE_W-1:0]  PRE_MAX  = PRE_W'(QUIET_PRE);
    localparam logic [POST_W-1:0] POST_LEN = POST_W'(QUIET_POST);

    logic [PRE_W-1:0]  run_q;
    logic [POST_W-1:0] hold_q;
    logic              bad_q;

    // Count consecutive idle cycles, saturating at QUIET_PRE
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (!idle)      run_q <= '0;
        else if (run_q != PRE_MAX) run_q <= run_q + 1'b1;
    end

    // Watch the post window that opens at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            bad_q  <= 1'b0;
        end else if (start) begin
            hold_q <= POST_LEN;
            bad_q  <= !idle;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
            bad_q  <= bad_q | !idle;
        end
    end

    assign pre_ok    = (run_q == PRE_MAX);
    assign hold_busy = (hold_q != '0);
    assign post_bad  = bad_q;

endmodule

// File: rtl/wake_seq_fsm.sv
// Module: wake_seq_fsm
// Sequences one wake attempt from synchronized serial edges: qualifies the
// falling edge, checks the command at the next rising edge, takes the address
// at the selected rising edge, waits for the quiet window to close and then
// issues a one-cycle strobe.
// Assumes: addr_ignore, addr_late and dev_id are static during an attempt.
module wake_seq_fsm
    import wake_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_fall,
    input  logic              sck_rise,
    input  logic              cmd_s,
    input  logic              sio_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic              clk_stable,
    input  logic              addr_ignore,
    input  logic              addr_late,
    input  logic [ADDR_W-1:0] dev_id,
    input  logic              pre_ok,
    input  logic              hold_busy,
    input  logic              post_bad,
    output logic              accept,
    output logic              exit_pulse,
    output logic              exit_is_pdn
);

    wake_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_cap_q, addr_cap_d;
    logic              skip_q, skip_d;
    logic              type_q, type_d;
    logic              fire_d;
    logic              pulse_q, pdn_q;

    // Next-state and capture decisions for the attempt
    always_comb begin
        state_d    = state_q;
        addr_cap_d = addr_cap_q;
        skip_d     = skip_q;
        type_d     = type_q;
        accept     = 1'b0;
        fire_d     = 1'b0;
        case (state_q)
            WS_IDLE: begin
                if (sck_fall && !cmd_s && clk_stable && pre_ok) begin
                    accept  = 1'b1;
                    type_d  = sio_s;
                    state_d = WS_WAIT_R1;
                end
            end
            WS_WAIT_R1: begin
                if (sck_rise) begin
                    if (!cmd_s) begin
                        state_d = WS_IDLE;
                    end else if (addr_ignore) begin
                        skip_d  = 1'b1;
                        state_d = WS_SETTLE;
                    end else if (!addr_late) begin
                        skip_d     = 1'b0;
                        addr_cap_d = addr_s;
                        state_d    = WS_SETTLE;
                    end else begin
                        state_d = WS_WAIT_F2;
                    end
                end
            end
            WS_WAIT_F2: begin
                if (sck_fall) state_d = WS_WAIT_R2;
            end
            WS_WAIT_R2: begin
                if (sck_rise) begin
                    skip_d     = 1'b0;
                    addr_cap_d = addr_s;
                    state_d    = WS_SETTLE;
                end
            end
            WS_SETTLE: begin
                if (!hold_busy) begin
                    fire_d  = !post_bad && (skip_q || (addr_cap_q == dev_id));
                    state_d = WS_IDLE;
                end
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // Attempt state and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= WS_IDLE;
            addr_cap_q <= '0;
            skip_q     <= 1'b0;
            type_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            addr_cap_q <= addr_cap_d;
            skip_q     <= skip_d;
            type_q     <= type_d;
        end
    end

    // Registered strobe and held exit type
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            pdn_q   <= 1'b0;
        end else begin
            pulse_q <= fire_d;
            if (fire_d) pdn_q <= type_q;
        end
    end

    assign exit_pulse  = pulse_q;
    assign exit_is_pdn = pdn_q;

endmodule

// File: rtl/wake_seq_detect.sv
// Module: wake_seq_detect (top)
// Serial wake-up detector: synchronizes the serial wires, delays the bus-idle
// flag by the same depth, finds serial clock edges and drives the sequencer.
// Assumes: sck half period is many clk cycles longer than SYNC_STAGES+1, and
// row_bus/col_bus are in the clk domain.
module wake_seq_detect #(
    parameter int ADDR_W      = 6,
    parameter int ROW_W       = 3,
    parameter int COL_W       = 5,
    parameter int SYNC_STAGES = 2,
    parameter int QUIET_PRE   = 4,
    parameter int QUIET_POST  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cmd,
    input  logic              sio0,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [ROW_W-1:0]  row_bus,
    input  logic [COL_W-1:0]  col_bus,
    input  logic              clk_stable,
    input  logic              addr_ignore,
    input  logic              addr_late,
    input  logic [ADDR_W-1:0] dev_id,
    output logic              exit_pulse,
    output logic              exit_is_pdn
);

    localparam int BUS_W = ADDR_W + 3;

    logic [BUS_W-1:0]  bus_s;
    logic              idle_raw, idle_s;
    logic              sck_s, cmd_s, sio_s;
    logic [ADDR_W-1:0] addr_s;
    logic              sck_prev;
    logic              sck_fall, sck_rise;
    logic              accept, pre_ok, hold_busy, post_bad;

    assign idle_raw = ~|row_bus & ~|col_bus;

    wake_in_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck, cmd, sio0, dev_addr}),
        .q     (bus_s)
    );

    wake_in_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (idle_raw),
        .q     (idle_s)
    );

    assign {sck_s, cmd_s, sio_s, addr_s} = bus_s;

    // Previous synchronized serial clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign sck_fall = sck_prev & ~sck_s;
    assign sck_rise = ~sck_prev & sck_s;

    wake_quiet_mon #(.QUIET_PRE(QUIET_PRE), .QUIET_POST(QUIET_POST)) u_quiet (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle_s),
        .start     (accept),
        .pre_ok    (pre_ok),
        .hold_busy (hold_busy),
        .post_bad  (post_bad)
    );

    wake_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_fall    (sck_fall),
        .sck_rise    (sck_rise),
        .cmd_s       (cmd_s),
        .sio_s       (sio_s),
        .addr_s      (addr_s),
        .clk_stable  (clk_stable),
        .addr_ignore (addr_ignore),
        .addr_late   (addr_late),
        .dev_id      (dev_id),
        .pre_ok      (pre_ok),
        .hold_busy   (hold_busy),
        .post_bad    (post_bad),
        .accept      (accept),
        .exit_pulse  (exit_pulse),
        .exit_is_pdn (exit_is_pdn)
    );

endmodule

// File: rtl/wake_seq_detect_chk.sv
// Module: wake_seq_detect_chk
// Property checker bound into wake_seq_detect; relates the strobe to the
// quiet monitor, the sequencer state and the captured address.
// Assumes: bound through the statement at the end of this file.
module wake_seq_detect_chk
    import wake_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exit_pulse,
    input logic              addr_ignore,
    input logic [ADDR_W-1:0] dev_id,
    input wake_state_t       state,
    input logic [ADDR_W-1:0] addr_cap,
    input logic              hold_busy,
    input logic              post_bad
);

    // R9: strobe never lasts two cycles
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |=> !exit_pulse);

    // R9: strobe only follows the settle phase
    assert_pulse_after_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |-> $past(state == WS_SETTLE));

    // R6: no strobe while the post window is open
    assert_hold_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |-> !hold_busy);

    // R6: no strobe after a bus burst inside the window
    assert_quiet_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |-> !post_bad);

    // R3: addressed strobe means the captured address matched
    assert_addr_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_pulse && !addr_ignore) |-> (addr_cap == dev_id));

    // R8: after a strobe the sequencer is back at idle
    assert_back_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |-> (state == WS_IDLE));

endmodule

bind wake_seq_detect wake_seq_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exit_pulse  (exit_pulse),
    .addr_ignore (addr_ignore),
    .dev_id      (dev_id),
    .state       (u_fsm.state_q),
    .addr_cap    (u_fsm.addr_cap_q),
    .hold_busy   (u_quiet.hold_busy),
    .post_bad    (u_quiet.post_bad)
);

// File: tb/wake_seq_detect_bench.sv
`timescale 1ns/1ps
// Bench for wake_seq_detect: directed corner cases followed by seeded random
// attempts, each compared with an expected outcome from bench functions.
module wake_seq_detect_bench;

    localparam int HALF = 8;
    localparam int PRE  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1;
    logic       cmd = 1'b1;
    logic       sio0 = 1'b0;
    logic [5:0] dev_addr = '0;
    logic [2:0] row_bus = '0;
    logic [4:0] col_bus = '0;
    logic       clk_stable = 1'b1;
    logic       addr_ignore = 1'b0;
    logic       addr_late = 1'b0;
    logic [5:0] dev_id = 6'h15;
    logic       exit_pulse, exit_is_pdn;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    logic last_type = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wake_seq_detect u_wake_seq_detect (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cmd(cmd), .sio0(sio0),
        .dev_addr(dev_addr), .row_bus(row_bus), .col_bus(col_bus),
        .clk_stable(clk_stable), .addr_ignore(addr_ignore),
        .addr_late(addr_late), .dev_id(dev_id),
        .exit_pulse(exit_pulse), .exit_is_pdn(exit_is_pdn)
    );

    // Count strobes away from the active edge
    always @(negedge clk) begin
        if (rst_n && exit_pulse) begin
            pulses++;
            last_type = exit_is_pdn;
        end
    end

    function automatic bit exp_fire(bit cf, bit cr, bit cs, int viol, bit ign,
                                    bit late, logic [5:0] a1, logic [5:0] a2,
                                    logic [5:0] id);
        logic [5:0] used;
        used = late ? a2 : a1;
        return !cf && cr && cs && (viol != 1) && (viol != 2) && (ign || used == id);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // viol: 0 none, 1 burst inside pre span, 2 burst inside post span, 3 burst far before
    task automatic attempt(string req, bit cf, bit cr, bit sio, logic [5:0] a1,
                           logic [5:0] a2, int viol, bit cs, bit ign, bit late,
                           logic [5:0] id);
        int base;
        bit ef;
        base = pulses;
        ef = exp_fire(cf, cr, cs, viol, ign, late, a1, a2, id);
        addr_ignore = ign; addr_late = late; dev_id = id; clk_stable = cs;
        cmd = cf; sio0 = sio; dev_addr = a1;
        if (viol == 3) begin
            row_bus = 3'b010; wait_n(1); row_bus = '0; wait_n(HALF - 1);
        end else if (viol == 1) begin
            wait_n(HALF - 2); row_bus = 3'b001; wait_n(1); row_bus = '0; wait_n(1);
        end else begin
            wait_n(HALF);
        end
        sck = 1'b0;
        if (viol == 2) begin
            wait_n(1); col_bus = 5'b10000; wait_n(1); col_bus = '0; wait_n(HALF/2 - 2);
        end else begin
            wait_n(HALF/2);
        end
        cmd = cr;
        wait_n(HALF/2);
        sck = 1'b1;
        wait_n(HALF/2);
        dev_addr = a2; cmd = 1'b1;
        wait_n(HALF/2);
        sck = 1'b0;
        wait_n(HALF);
        sck = 1'b1;
        wait_n(HALF + 12);
        clk_stable = 1'b1;
        check(req, pulses - base, ef ? 1 : 0);
        if (ef && pulses - base == 1) check({req, " type"}, last_type, sio);
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_n(4);
        // R1: reset state
        check("R1", exit_pulse, 0);
        rst_n = 1'b1;
        wait_n(10);
        check("R1", exit_pulse, 0);
        // R2: nap and power-down exits
        attempt("R2 nap",  0, 1, 0, 6'h15, 6'h15, 0, 1, 0, 0, 6'h15);
        attempt("R2 pdn",  0, 1, 1, 6'h15, 6'h15, 0, 1, 0, 0, 6'h15);
        // R3: address mismatch
        attempt("R3 mismatch", 0, 1, 0, 6'h14, 6'h14, 0, 1, 0, 0, 6'h15);
        // R4: sampling offset
        attempt("R4 late",       0, 1, 1, 6'h00, 6'h2A, 0, 1, 0, 1, 6'h2A);
        attempt("R4 early",      0, 1, 0, 6'h2A, 6'h00, 0, 1, 0, 0, 6'h2A);
        attempt("R4 late wrong", 0, 1, 0, 6'h2A, 6'h00, 0, 1, 0, 1, 6'h2A);
        // R5: address ignored
        attempt("R5 ignore", 0, 1, 1, 6'h01, 6'h02, 0, 1, 1, 0, 6'h3F);
        attempt("R5 ignore late", 0, 1, 0, 6'h07, 6'h09, 0, 1, 1, 1, 6'h3F);
        // R6: quiet window
        attempt("R6 pre",  0, 1, 0, 6'h15, 6'h15, 1, 1, 0, 0, 6'h15);
        attempt("R6 post", 0, 1, 0, 6'h15, 6'h15, 2, 1, 0, 0, 6'h15);
        attempt("R6 far",  0, 1, 1, 6'h15, 6'h15, 3, 1, 0, 0, 6'h15);
        // R7: clock not stable
        attempt("R7 unstable", 0, 1, 0, 6'h15, 6'h15, 0, 0, 0, 0, 6'h15);
        // R8: bad command pattern, then recovery
        attempt("R8 cmd high at fall", 1, 1, 0, 6'h15, 6'h15, 0, 1, 0, 0, 6'h15);
        attempt("R8 cmd low at rise",  0, 0, 0, 6'h15, 6'h15, 0, 1, 1, 0, 6'h15);
        attempt("R8 recover",          0, 1, 1, 6'h15, 6'h15, 0, 1, 0, 1, 6'h15);
        // R9: random mix, strobe counted per attempt
        for (int i = 0; i < 40; i++) begin
            logic [5:0] id, a1, a2;
            id = 6'($urandom);
            a1 = ($urandom_range(0, 1) == 1) ? id : 6'($urandom);
            a2 = ($urandom_range(0, 1) == 1) ? id : 6'($urandom);
            attempt("R9 random", ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) != 0),
                    1'($urandom), a1, a2, $urandom_range(0, 5) > 3 ? $urandom_range(1, 3) : 0,
                    ($urandom_range(0, 4) != 0), 1'($urandom), 1'($urandom), id);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule